// File: doc/BRIEF.md
# Accumulator-Based PWM Generator

This block turns two run-time settings into a single-bit pulse-width-modulated output. A 32-bit phase accumulator adds a step value on every clock and wraps modulo 2^32. The step therefore sets how often the accumulator wraps, which is the PWM repetition rate. The accumulator is compared, unsigned, against a 32-bit threshold. The result is registered and drives the output.

The output period is 2^32 divided by the step, measured in clocks. The fraction of each period spent high is the threshold divided by 2^32. Both settings may change at any time. A new step takes effect on the next clock and never clears the accumulator, so the waveform changes rate without a phase jump.

Top module: `accum_pwm`

## Requirements
- R1: While the active-low reset `rst_n` is sampled low on a clock edge, the accumulator is cleared to zero and `pwm_out` goes to 0. After release, the accumulator starts counting from zero.
- R2: On every clock out of reset, the accumulator becomes its previous value plus `step_in`, wrapping modulo 2^32.
- R3: `pwm_out` is 1 in the cycle after the accumulator holds a value strictly below `thresh_in`, using an unsigned comparison.
- R4: `pwm_out` is 0 in the cycle after the accumulator holds a value equal to or above `thresh_in`.
- R5: With `thresh_in` equal to 0, `pwm_out` stays 0 in every cycle.
- R6: A change to `step_in` is used on the next clock edge, and the accumulator keeps its value across the change.
- R7: With `step_in` equal to 0, the accumulator holds its value, so `pwm_out` stays constant while the threshold is constant.
- R8: With `step_in` equal to 2^30, the output period is 4 clocks. A threshold of 2^31 gives the repeating pattern 1,1,0,0 counted from release of reset. A threshold of 2^30 gives the pattern 1,0,0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_in | input | 32 | Accumulator increment per clock (unsigned) |
| thresh_in | input | 32 | Duty threshold; the output is high while the accumulator is below it |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions assume that `rst_n` is low at the first clock edge. They also assume that `step_in` and `thresh_in` are stable around each rising edge. The bench meets both conditions: it holds reset from time zero and changes every input on the falling clock edge. Random phases draw the step and threshold from a fixed seed, and these are mixed with directed settings: a zero threshold, a zero step, a threshold equal to an accumulator value, a maximal threshold, and a step change without reset. The bench checks the output on every cycle against a model built from the requirements.

// File: rtl/pwm_acc_pkg.sv
// Package: shared widths for the accumulator PWM generator.
// Assumes: one accumulator width is used for the step, the threshold and the accumulator.
package pwm_acc_pkg;
    localparam int unsigned ACC_W_DEF = 32;
endpackage

// File: rtl/pwm_phase_acc.sv
// Module: pwm_phase_acc
// Free-running wrapping phase accumulator. It adds step_i on every clock edge.
// Assumes: synchronous active-low reset; the sum wraps naturally modulo 2^ACC_W.
module pwm_phase_acc #(
    parameter int unsigned ACC_W = pwm_acc_pkg::ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step_i,
    output logic [ACC_W-1:0] acc_o
);
    logic [ACC_W-1:0] acc_q;

    // Purpose: advance the phase by the current step, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + step_i;
    end

    assign acc_o = acc_q;

    // R1: the accumulator is zero in the first cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> acc_q == '0);

    // R7: a zero step holds the phase
    assert_zero_step_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step_i) == '0) |-> $stable(acc_q));
endmodule

// File: rtl/pwm_duty_cmp.sv
// Module: pwm_duty_cmp
// Registered unsigned comparison of the phase against the duty threshold.
// Assumes: acc_i comes from a register in the same clock domain.
module pwm_duty_cmp #(
    parameter int unsigned ACC_W = pwm_acc_pkg::ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] thresh_i,
    output logic             pwm_o
);
    logic below;
    logic pwm_q;

    // Purpose: flag a phase strictly below the threshold (unsigned).
    always_comb below = (acc_i < thresh_i);

    // Purpose: register the flag so the output is free of glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= below;
    end

    assign pwm_o = pwm_q;

    // R5: a zero threshold never lets the output rise
    assert_zero_thresh_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(thresh_i) == '0) |-> !pwm_q);
endmodule

// File: rtl/accum_pwm.sv
// Module: accum_pwm (top)
// PWM generator: a wrapping phase accumulator followed by a registered threshold compare.
// Assumes: step_in and thresh_in are synchronous to clk; reset is synchronous and active low.
module accum_pwm #(
    parameter int unsigned ACC_W = pwm_acc_pkg::ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step_in,
    input  logic [ACC_W-1:0] thresh_in,
    output logic             pwm_out
);
    logic [ACC_W-1:0] phase;

    pwm_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_in),
        .acc_o  (phase)
    );

    pwm_duty_cmp #(.ACC_W(ACC_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (phase),
        .thresh_i (thresh_in),
        .pwm_o    (pwm_out)
    );

    // R3: a phase below the threshold drives the output high one cycle later
    assert_high_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(phase) < $past(thresh_in))) |-> pwm_out);

    // R4: a phase at or above the threshold drives the output low one cycle later
    assert_low_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(phase) >= $past(thresh_in))) |-> !pwm_out);
endmodule

// File: tb/accum_pwm_tb.sv
module accum_pwm_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] step_in = '0;
    logic [31:0] thresh_in = '0;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_acc = '0;
    logic        m_pwm = 1'b0;

    accum_pwm u_dut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in),
        .thresh_in(thresh_in), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model built from R1-style rules: clear, add step, compare below threshold.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0;
            m_pwm = 1'b0;
        end else begin
            m_pwm = (m_acc < thresh_in);
            m_acc = m_acc + step_in;
        end
    end

    function automatic string req_of(input logic e);
        return e ? "R3" : "R4";
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Run n cycles, checking the output at each falling edge.
    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_bit(req == "" ? req_of(m_pwm) : req, pwm_out, m_pwm);
        end
    endtask

    task automatic check_pattern(input string req, input logic [3:0] pat);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check_bit(req, pwm_out, pat[3 - (i % 4)]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_bit("R1", pwm_out, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        logic held;
        void'($urandom(32'h5EED_1234));
        // R1: reset state
        thresh_in = 32'h8000_0000;
        step_in   = 32'h1000_0000;
        repeat (3) @(negedge clk);
        check_bit("R1", pwm_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1", pwm_out, 1'b1);   // phase 0 < threshold
        run(40, "R2");

        // R8: step of 2^30 with half threshold gives 1,1,0,0
        step_in = 32'h4000_0000; thresh_in = 32'h8000_0000;
        do_reset();
        check_pattern("R8", 4'b1100);

        // R8: threshold equal to an accumulator value gives 1,0,0,0
        thresh_in = 32'h4000_0000;
        do_reset();
        check_pattern("R8", 4'b1000);

        // R5: zero threshold keeps output low
        thresh_in = '0; step_in = 32'h0123_4567;
        run(30, "R5");
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check_bit("R5", pwm_out, 1'b0);
        end

        // R4: maximal threshold, phase reaches all-ones only rarely
        thresh_in = 32'hFFFF_FFFF; step_in = 32'hFFFF_FFFF;
        do_reset();
        run(20, "");

        // R7: zero step holds phase, output constant
        thresh_in = 32'h9000_0000; step_in = 32'h3000_0000;
        run(5, "");
        step_in = '0;
        @(negedge clk);
        check_bit("R7", pwm_out, m_pwm);
        held = pwm_out;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check_bit("R7", pwm_out, held);
        end

        // R6: step change without reset keeps phase
        step_in = 32'h2000_0000;
        run(10, "R6");
        step_in = 32'h0800_0000;
        run(40, "R6");
        step_in = 32'hE000_0000;
        run(20, "R6");

        // Random phases for R2/R3/R4
        for (int p = 0; p < 60; p++) begin
            step_in = $urandom();
            if (p % 3 == 0) step_in = step_in >> ($urandom() % 28);
            thresh_in = $urandom();
            if (p % 7 == 0) do_reset();
            run(200, "");
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule